// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and presents them to it as a single request with a vector address. It has three sources. The first is an external pin, which is brought into the clock domain by a flop synchronizer and then passed through an edge detector whose sensitivity software selects. The second is a timer event pulse and the third is a periodic time-base tick. Each source has a sticky request flag and an enable bit. A global master enable gates all three. Requests are also held back while the core reports that its call stack is full.

The host sees one control byte and a separate 2-bit edge-select field. In the control byte, bit 0 is the master enable, bit 1 the external enable, bit 2 the timer enable, bit 3 the time-base enable, bit 4 the external flag, bit 5 the timer flag and bit 6 the time-base flag. Bit 7 always reads 0. A small two-state machine sits between the flags and the core. In `ST_IDLE` it waits until a source is pending, meaning the master enable, that source's enable and its flag are all 1 and the stack is not full. It then latches the highest-priority source and takes the transition *take* into `ST_REQ`. In `ST_REQ` it drives the request with a fixed vector until the core acknowledges. The acknowledge takes the transition *serve* back to `ST_IDLE`, clears the served flag and clears the master enable. A return-from-interrupt strobe sets the master enable again.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the edge-select field reads 00 and no request is asserted.
- R2: The edge-select field controls the external flag (bit 4). Code 00 sets nothing, 01 sets the flag on a rising pin edge, 10 on a falling edge and 11 on either edge. The flag becomes visible on the third clock edge after the pin changes.
- R3: When `ext_is_input` is 0, pin transitions never set the external flag.
- R4: A one-cycle `tmr_evt` pulse sets bit 5 and a `tb_evt` pulse sets bit 6. A set flag stays set until it is cleared by software or by service.
- R5: In `ST_IDLE`, `irq_req` rises on the clock edge after a source becomes pending. While `stack_full` is 1 the request stays low.
- R6: Priority is external, then timer, then time base. The vectors are 0x04, 0x08 and 0x0C respectively.
- R7: While `irq_req` is high and `irq_ack` is low, `irq_req` stays high and `irq_vec` does not change, even if a higher-priority source becomes pending.
- R8: When `irq_ack` is high during `ST_REQ`, the next clock returns to `ST_IDLE`, clears the served source's flag and clears the master enable (bit 0).
- R9: A `reti` pulse sets the master enable to 1 on the next clock.
- R10: A hardware event that sets a flag wins over a software write in the same cycle.
- R11: Bit 7 of the control byte ignores writes and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_is_input | input | 1 | Port direction bit; 1 means the pin is an input |
| tmr_evt | input | 1 | Timer event pulse |
| tb_evt | input | 1 | Time-base tick pulse |
| stack_full | input | 1 | Core call stack is full |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rd | output | 8 | Control byte read value |
| edge_wr | input | 1 | Write strobe for the edge-select field |
| edge_wdata | input | 2 | Edge-select write data |
| edge_rd | output | 2 | Edge-select read value |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address, valid while `irq_req` is high |
| irq_ack | input | 1 | Core acknowledge |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
The external pin is toggled rising and then falling under each of the four edge codes. This separates the codes by which direction, if any, sets the flag, and a further run with the pin configured as an output shows the direction gate. Fully loaded flag sets are served one by one through acknowledge and return, which distinguishes the priority order from the vector values. A late higher-priority flag raised during a pending request shows that the vector is held stable. Random mixes of event pulses, register writes, stack-full periods, acknowledges and returns are then compared each cycle against a bench model. This catches ordering faults between software writes and hardware set or clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } irq_st_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    localparam int N_SRC    = 3;
    localparam int IDX_W    = 2;
    // control byte bit positions (software-visible layout)
    localparam int B_EMI    = 0;
    localparam int B_EN0    = 1;   // enables at 1..3 in priority order
    localparam int B_FLAG0  = 4;   // flags at 4..6 in priority order
    localparam int REG_W    = 7;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       pin_is_in,
    input  logic [1:0] mode,
    output logic       hit
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;
    logic cur, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[PIPE_W-2:0], pin};
    end

    assign cur  = pipe_q[SYNC_STAGES-1];
    assign prev = pipe_q[SYNC_STAGES];

    always_comb begin
        hit = 1'b0;
        unique case (edge_e'(mode))
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = cur & ~prev;
            EDGE_FALL: hit = ~cur & prev;
            EDGE_BOTH: hit = cur ^ prev;
        endcase
        hit = hit & pin_is_in;
    end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             edge_wr,
    input  logic [1:0]       edge_wdata,
    input  logic [N_SRC-1:0] set_ev,
    input  logic             srv,
    input  logic [IDX_W-1:0] srv_idx,
    input  logic             reti,
    output logic [7:0]       rd,
    output logic [1:0]       edge_mode,
    output logic             emi,
    output logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] flags
);
    logic [REG_W-1:0] reg_q, reg_d;
    logic [1:0]       edge_q;
    logic             unused_wr_hi;

    assign unused_wr_hi = wdata[7];

    always_comb begin
        reg_d = reg_q;
        if (wr) reg_d = wdata[REG_W-1:0];
        if (reti) reg_d[B_EMI] = 1'b1;
        if (srv) begin
            reg_d[B_EMI] = 1'b0;
            reg_d[B_FLAG0 + int'(srv_idx)] = 1'b0;
        end
        for (int i = 0; i < N_SRC; i++)
            if (set_ev[i]) reg_d[B_FLAG0 + i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q  <= '0;
            edge_q <= EDGE_OFF;
        end else begin
            reg_q <= reg_d;
            if (edge_wr) edge_q <= edge_wdata;
        end
    end

    assign rd        = {1'b0, reg_q};
    assign edge_mode = edge_q;
    assign emi       = reg_q[B_EMI];
    assign en        = reg_q[B_EN0 +: N_SRC];
    assign flags     = reg_q[B_FLAG0 +: N_SRC];
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--)
            if (pend[i]) idx = IDX_W'(i);
        any = |pend;
        vec = VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8,
    parameter int VEC_BASE    = 4,
    parameter int VEC_STEP    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             ext_is_input,
    input  logic             tmr_evt,
    input  logic             tb_evt,
    input  logic             stack_full,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rd,
    input  logic             edge_wr,
    input  logic [1:0]       edge_wdata,
    output logic [1:0]       edge_rd,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             reti
);
    irq_st_e          st_q, st_d;
    logic             ext_hit, emi, take, serve, arb_any;
    logic [N_SRC-1:0] en, flags, pend;
    logic [IDX_W-1:0] arb_idx, src_q;
    logic [VEC_W-1:0] arb_vec, vec_q;

    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pin_is_in(ext_is_input),
        .mode(edge_rd), .hit(ext_hit)
    );

    irq_ctl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .edge_wr(edge_wr), .edge_wdata(edge_wdata),
        .set_ev({tb_evt, tmr_evt, ext_hit}),
        .srv(serve), .srv_idx(src_q), .reti(reti),
        .rd(ctl_rd), .edge_mode(edge_rd), .emi(emi), .en(en), .flags(flags)
    );

    assign pend = en & flags;

    irq_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .pend(pend), .any(arb_any), .idx(arb_idx), .vec(arb_vec)
    );

    assign take = emi & arb_any & ~stack_full;

    // next-state process
    always_comb begin
        st_d  = st_q;
        serve = 1'b0;
        unique case (st_q)
            ST_IDLE: if (take) st_d = ST_REQ;
            ST_REQ: if (irq_ack) begin
                st_d  = ST_IDLE;
                serve = 1'b1;
            end
        endcase
    end

    // state register, with source and vector latched on take
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            src_q <= '0;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && take) begin
                src_q <= arb_idx;
                vec_q <= arb_vec;
            end
        end
    end

    // output process
    always_comb begin
        irq_req = (st_q == ST_REQ);
        irq_vec = vec_q;
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stack_full,
    input logic [7:0] ctl_rd,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       irq_ack,
    input logic       reti
);
    p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> !irq_req);

    p_stack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && stack_full) |=> !irq_req);

    p_rise_needs_emi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !ctl_rd[0]) |=> !irq_req);

    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == 8'h04 || irq_vec == 8'h08 || irq_vec == 8'h0C));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    p_ack_serve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !reti) |=> (!irq_req && !ctl_rd[0]));

    p_reti_emi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq_req && irq_ack)) |=> ctl_rd[0]);

    p_top_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd[7]);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stack_full(stack_full), .ctl_rd(ctl_rd),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, ext_is_input = 1'b1, tmr_evt = 1'b0, tb_evt = 1'b0;
    logic       stack_full = 1'b0, ctl_wr = 1'b0, edge_wr = 1'b0, irq_ack = 1'b0, reti = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [1:0] edge_wdata = '0;
    logic [7:0] ctl_rd, irq_vec;
    logic [1:0] edge_rd;
    logic       irq_req;

    int n_chk = 0, n_fail = 0;

    // bench reference state
    logic [6:0] m_reg;
    logic       m_req;
    int         m_src;

    irq_vec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_is_input(ext_is_input),
        .tmr_evt(tmr_evt), .tb_evt(tb_evt), .stack_full(stack_full),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
        .edge_wr(edge_wr), .edge_wdata(edge_wdata), .edge_rd(edge_rd),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_vec(int idx);
        return 8'(4 + 4 * idx);
    endfunction

    function automatic int prio(logic [6:0] r);
        logic [2:0] p;
        p = r[3:1] & r[6:4];
        if (p[0]) return 0;
        if (p[1]) return 1;
        return 2;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick(1);
        ctl_wr = 1'b0;
    endtask

    task automatic set_edge(logic [1:0] m);
        edge_wr = 1'b1; edge_wdata = m;
        tick(1);
        edge_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(1); reti = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 ctl", ctl_rd, 8'h00);
        check("R1 edge", edge_rd, 2'b00);
        check("R1 req", irq_req, 1'b0);

        // R11 top bit ignored
        wr_ctl(8'hFE);
        check("R11 readback", ctl_rd, 8'h7E);
        wr_ctl(8'h00);

        // R2 edge modes
        for (int m = 0; m < 4; m++) begin
            set_edge(2'(m));
            tick(4);
            wr_ctl(8'h00);
            ext_pin = 1'b1; tick(4);
            check("R2 rise", ctl_rd[4], (m == 1 || m == 3));
            wr_ctl(8'h00);
            ext_pin = 1'b0; tick(4);
            check("R2 fall", ctl_rd[4], (m == 2 || m == 3));
            wr_ctl(8'h00);
        end
        // R2 latency: flag visible on third edge
        set_edge(2'b01);
        ext_pin = 1'b1; tick(2);
        check("R2 early", ctl_rd[4], 1'b0);
        tick(1);
        check("R2 latency", ctl_rd[4], 1'b1);
        ext_pin = 1'b0; tick(4);
        wr_ctl(8'h00);

        // R3 pin configured as output
        ext_is_input = 1'b0;
        set_edge(2'b11);
        ext_pin = 1'b1; tick(4);
        ext_pin = 1'b0; tick(4);
        check("R3 gated", ctl_rd[4], 1'b0);
        ext_is_input = 1'b1;
        set_edge(2'b00);

        // R4 sticky timer and time-base flags
        tmr_evt = 1'b1; tick(1); tmr_evt = 1'b0;
        check("R4 tmr", ctl_rd, 8'h20);
        tb_evt = 1'b1; tick(1); tb_evt = 1'b0;
        tick(3);
        check("R4 sticky", ctl_rd, 8'h60);

        // R10 hardware set beats software write
        tmr_evt = 1'b1; wr_ctl(8'h00); tmr_evt = 1'b0;
        check("R10 set wins", ctl_rd, 8'h20);
        wr_ctl(8'h00);

        // R5 stack full holds request
        stack_full = 1'b1;
        wr_ctl(8'h25);
        tick(3);
        check("R5 held", irq_req, 1'b0);
        stack_full = 1'b0;
        tick(1);
        check("R5 raised", irq_req, 1'b1);
        check("R6 tmr vec", irq_vec, 8'h08);
        pulse_ack();
        check("R8 tmr served", ctl_rd, 8'h04);

        // R6 priority walk
        wr_ctl(8'h7E);
        wr_ctl(8'h7F);
        tick(1);
        check("R6 ext first", irq_vec, 8'h04);
        pulse_ack();
        check("R8 ext served", ctl_rd, 8'h6E);
        check("R8 idle", irq_req, 1'b0);
        pulse_reti();
        check("R9 emi set", ctl_rd[0], 1'b1);
        tick(1);
        check("R6 tmr second", irq_vec, 8'h08);
        pulse_ack(); pulse_reti(); tick(1);
        check("R6 tb last", irq_vec, 8'h0C);
        pulse_ack();
        check("R8 all served", ctl_rd, 8'h0E);

        // R7 vector held against a late higher-priority flag
        wr_ctl(8'h49);
        tick(1);
        check("R7 req", irq_req, 1'b1);
        wr_ctl(8'h5B);
        tick(3);
        check("R7 still req", irq_req, 1'b1);
        check("R7 vec stable", irq_vec, 8'h0C);
        pulse_ack();
        check("R8 tb cleared", ctl_rd, 8'h1A);

        // random phase against a bench model (external source quiet)
        wr_ctl(8'h00);
        m_reg = 7'h00; m_req = 1'b0; m_src = 0;
        for (int c = 0; c < N_RAND; c++) begin
            logic       r_wr, r_tm, r_tb, r_sf, r_ak, r_rt, tk;
            logic [7:0] r_wd;
            logic [6:0] nr;
            check("R4/R5/R8/R9/R10 rand ctl", ctl_rd, {1'b0, m_reg});
            check("R5/R7 rand req", irq_req, m_req);
            if (m_req) check("R6 rand vec", irq_vec, exp_vec(m_src));
            r_wr = ($urandom % 8) == 0;
            r_wd = 8'($urandom);
            r_tm = ($urandom % 6) == 0;
            r_tb = ($urandom % 6) == 0;
            r_sf = ($urandom % 4) == 0;
            r_ak = m_req && (($urandom % 3) == 0);
            r_rt = ($urandom % 10) == 0;
            tk = !m_req && m_reg[0] && |(m_reg[3:1] & m_reg[6:4]) && !r_sf;
            nr = m_reg;
            if (r_wr) nr = r_wd[6:0];
            if (r_rt) nr[0] = 1'b1;
            if (r_ak) begin nr[0] = 1'b0; nr[4 + m_src] = 1'b0; end
            if (r_tm) nr[5] = 1'b1;
            if (r_tb) nr[6] = 1'b1;
            if (tk) begin m_req = 1'b1; m_src = prio(m_reg); end
            else if (r_ak) m_req = 1'b0;
            m_reg = nr;
            ctl_wr = r_wr; ctl_wdata = r_wd; tmr_evt = r_tm; tb_evt = r_tb;
            stack_full = r_sf; irq_ack = r_ak; reti = r_rt;
            tick(1);
        end
        ctl_wr = 0; tmr_evt = 0; tb_evt = 0; stack_full = 0; irq_ack = 0; reti = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule